// File: doc/BRIEF.md
# I2C Bus Hang Recovery Sequencer

This block frees an I2C bus that a slave has left stuck in the middle of a byte, holding SDA low. A one-cycle start pulse launches the recovery. The sequencer first samples SDA through a two-flop synchronizer. As long as SDA reads low, it clocks SCL one pulse at a time, sampling again before every pulse. It stops pulsing as soon as SDA reads high or when a fixed pulse budget runs out. It then forces a clean STOP with four ordered edges on the open-drain enables. Finally it raises a one-cycle reset request for the bus controller and waits a settle interval before it reports completion.

The block drives the bus only through open-drain enables: an enable of 1 pulls the line low, and an enable of 0 releases it. All phase lengths are parameters counted in core-clock cycles. The number of pulses issued stays on an output from the end of a run until the next run starts. Start, busy, done and the reset request are plain level or pulse signals with no handshake. A bus that is already idle at trigger time receives no pulses, but it still gets the forced STOP and the controller reset.

Top module: `i2c_hang_recovery`

## Requirements
- R1: Out of reset, busy, done, the reset request and both line enables are 0, and the pulse count is 0. While busy is 0, neither line enable is asserted.
- R2: A start pulse seen while busy is 0 sets busy on the next cycle. A start pulse seen while busy is 1 has no effect on the sequence, its timing or the reported count.
- R3: One cycle after start, and again after every pulse, the synchronized SDA is checked. If it reads high, the loop ends without pulsing. If it reads low, another pulse is issued.
- R4: The loop issues at most MAX_PULSES pulses (default 9), even if SDA never releases.
- R5: Each pulse holds the SCL enable at 1 for exactly LONG_PHASE cycles and then at 0 for LONG_PHASE cycles. One further check cycle follows before the next decision.
- R6: After the loop, the enable pair (SCL, SDA) steps through 10, 11, 01 and 00, and each step lasts SHORT_PHASE cycles. SDA is pulled low only while SCL is pulled low, and SDA is released only while SCL is released.
- R7: Directly after the STOP, the controller reset request is high for exactly one cycle. It is followed by SETTLE cycles with all outputs quiet, and then done.
- R8: The pulse count output equals the number of pulses issued in the last run (0 to MAX_PULSES). It is cleared when a run starts.
- R9: A bus that is idle at trigger time gets zero pulses but still gets the full STOP and reset sequence.
- R10: done is high for exactly one cycle at the end of a run, while busy is still 1. busy drops on the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle recovery trigger |
| sda_i | input | 1 | Sensed SDA line level (asynchronous) |
| busy_o | output | 1 | High from the cycle after start until done completes |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| pulse_count_o | output | CNT_W | Pulses issued in the last or current run |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| ctrl_rst_o | output | 1 | One-cycle reset request to the bus controller |

## Verification
The bench builds the block with LONG_PHASE=8, SHORT_PHASE=3 and SETTLE=5, and keeps MAX_PULSES at 9. With these values a full nine-pulse run lasts under 180 cycles, so many runs fit in a short simulation. The short phases let every cycle of every run be compared against a computed trace. The long phase is still several times the synchronizer delay, so the modelled slave's release is always visible at the next check. Because the budget stays at 9, slaves that release after 0, 1 and 9 pulses can all be tried, and so can slaves that stay stuck, which exercises the cap.

// File: rtl/i2c_recov_pkg.sv
package i2c_recov_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_PULSE_LO,
    ST_PULSE_HI,
    ST_STOP_A,
    ST_STOP_B,
    ST_STOP_C,
    ST_STOP_D,
    ST_RESET,
    ST_SETTLE,
    ST_DONE
  } recov_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/i2c_recov_sync.sv
module i2c_recov_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  // Reset to 1: a released bus reads high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_recov_timer.sv
module i2c_recov_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_recov_seq.sv
module i2c_recov_seq
  import i2c_recov_pkg::*;
#(
  parameter int MAX_PULSES  = 9,
  parameter int LONG_PHASE  = 5000,
  parameter int SHORT_PHASE = 1000,
  parameter int SETTLE      = 10000,
  parameter int CNT_W       = 4,
  parameter int TMR_W       = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sda_sync_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [TMR_W-1:0] tmr_val_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] pulse_count_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             ctrl_rst_o
);
  localparam logic [TMR_W-1:0] LONG_LD   = TMR_W'(LONG_PHASE - 1);
  localparam logic [TMR_W-1:0] SHORT_LD  = TMR_W'(SHORT_PHASE - 1);
  localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(MAX_PULSES);

  recov_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = SHORT_LD;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_CHECK;
        cnt_d   = '0;
      end
      ST_CHECK: begin
        tmr_load_o = 1'b1;
        if (sda_sync_i || cnt_q == CNT_MAX) begin
          state_d   = ST_STOP_A;
          tmr_val_o = SHORT_LD;
        end else begin
          state_d   = ST_PULSE_LO;
          tmr_val_o = LONG_LD;
          cnt_d     = cnt_q + 1'b1;
        end
      end
      ST_PULSE_LO: if (tmr_zero_i) begin
        state_d    = ST_PULSE_HI;
        tmr_load_o = 1'b1;
        tmr_val_o  = LONG_LD;
      end
      ST_PULSE_HI: if (tmr_zero_i) state_d = ST_CHECK;
      ST_STOP_A: if (tmr_zero_i) begin
        state_d    = ST_STOP_B;
        tmr_load_o = 1'b1;
      end
      ST_STOP_B: if (tmr_zero_i) begin
        state_d    = ST_STOP_C;
        tmr_load_o = 1'b1;
      end
      ST_STOP_C: if (tmr_zero_i) begin
        state_d    = ST_STOP_D;
        tmr_load_o = 1'b1;
      end
      ST_STOP_D: if (tmr_zero_i) state_d = ST_RESET;
      ST_RESET: begin
        state_d    = ST_SETTLE;
        tmr_load_o = 1'b1;
        tmr_val_o  = SETTLE_LD;
      end
      ST_SETTLE: if (tmr_zero_i) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_DONE);
  assign ctrl_rst_o    = (state_q == ST_RESET);
  assign scl_oe_o      = (state_q == ST_PULSE_LO) || (state_q == ST_STOP_A) ||
                         (state_q == ST_STOP_B);
  assign sda_oe_o      = (state_q == ST_STOP_B) || (state_q == ST_STOP_C);
  assign pulse_count_o = cnt_q;

  // R1: lines untouched when not busy
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));
  // R2: start from idle raises busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  // R4: count never exceeds budget
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_count_o <= CNT_MAX);
  // R6: SDA pulled low only while SCL is pulled low
  p_sda_fall_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> scl_oe_o);
  // R6: SDA released only while SCL is released
  p_sda_rise_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> !scl_oe_o);
  // R7: reset request lasts one cycle
  p_rst_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst_o |=> !ctrl_rst_o);
  // R10: done is a single-cycle pulse followed by idle
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
endmodule

// File: rtl/i2c_hang_recovery.sv
module i2c_hang_recovery
  import i2c_recov_pkg::*;
#(
  parameter int MAX_PULSES  = 9,
  parameter int LONG_PHASE  = 5000,
  parameter int SHORT_PHASE = 1000,
  parameter int SETTLE      = 10000,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(MAX_PULSES + 1),
  localparam int TMR_W      = $clog2(max3(LONG_PHASE, SHORT_PHASE, SETTLE) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sda_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] pulse_count_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             ctrl_rst_o
);
  logic             sda_sync;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_zero;

  i2c_recov_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sda_i),
    .q_o   (sda_sync)
  );

  i2c_recov_timer #(.W(TMR_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  i2c_recov_seq #(
    .MAX_PULSES  (MAX_PULSES),
    .LONG_PHASE  (LONG_PHASE),
    .SHORT_PHASE (SHORT_PHASE),
    .SETTLE      (SETTLE),
    .CNT_W       (CNT_W),
    .TMR_W       (TMR_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .sda_sync_i    (sda_sync),
    .tmr_zero_i    (tmr_zero),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .pulse_count_o (pulse_count_o),
    .scl_oe_o      (scl_oe_o),
    .sda_oe_o      (sda_oe_o),
    .ctrl_rst_o    (ctrl_rst_o)
  );
endmodule

// File: tb/i2c_hang_recovery_tb.sv
module i2c_hang_recovery_tb;
  localparam int LP = 8;
  localparam int SP = 3;
  localparam int SE = 5;
  localparam int MP = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic sda_i;
  logic busy_o, done_o, scl_oe_o, sda_oe_o, ctrl_rst_o;
  logic [3:0] pulse_count_o;

  int checks = 0;
  int failures = 0;
  int hold_k = 0;
  int seen = 0;
  logic scl_prev = 1'b0;
  logic [3:0] tr [0:1023];

  always #2 clk = ~clk;

  // Slave model: holds SDA low until it has seen hold_k SCL pulses.
  assign sda_i = (seen < hold_k) ? 1'b0 : ~sda_oe_o;

  i2c_hang_recovery #(.MAX_PULSES(MP), .LONG_PHASE(LP), .SHORT_PHASE(SP), .SETTLE(SE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sda_i(sda_i),
    .busy_o(busy_o), .done_o(done_o), .pulse_count_o(pulse_count_o),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .ctrl_rst_o(ctrl_rst_o));

  always @(negedge clk) begin
    if (scl_oe_o && !scl_prev) seen <= seen + 1;
    scl_prev <= scl_oe_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected per-cycle code {done,rst,sda_oe,scl_oe} from the requirements.
  function automatic logic [3:0] exp_code(input int i, input int p);
    int t = i;
    if (t == 0) return 4'd0;
    t -= 1;
    if (t < p * (2*LP + 1)) return ((t % (2*LP + 1)) < LP) ? 4'd1 : 4'd0;
    t -= p * (2*LP + 1);
    if (t < SP) return 4'd1; t -= SP;
    if (t < SP) return 4'd3; t -= SP;
    if (t < SP) return 4'd2; t -= SP;
    if (t < SP) return 4'd0; t -= SP;
    if (t == 0) return 4'd4; t -= 1;
    if (t < SE) return 4'd0;
    return 4'd8;
  endfunction

  function automatic int exp_len(input int p);
    return 1 + p * (2*LP + 1) + 4*SP + 1 + SE + 1;
  endfunction

  task automatic run(input int k, input bit spam);
    int p, n, len, bad5, bad6, bad7, first, dones, r6_end;
    p = (k < MP) ? k : MP;
    n = exp_len(p);
    r6_end = 1 + p * (2*LP + 1) + 4*SP;
    hold_k = k;
    seen = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R2 busy after start", busy_o, 1);
    check(pulse_count_o === 4'd0, "R8 count cleared at start", pulse_count_o, 0);
    len = 0;
    dones = 0;
    while (busy_o && len < 1024) begin
      tr[len] = {done_o, ctrl_rst_o, sda_oe_o, scl_oe_o};
      if (done_o) dones++;
      len++;
      start_i = spam && (len == 3 || len == n/2 || len == n-1);
      @(negedge clk);
    end
    start_i = 1'b0;
    check(len == n, "R2 run length (start while busy ignored)", len, n);
    bad5 = 0; bad6 = 0; bad7 = 0; first = -1;
    for (int i = 0; i < n && i < len; i++) begin
      if (tr[i] !== exp_code(i, p)) begin
        if (first < 0) first = i;
        if (i < 1 + p * (2*LP + 1)) bad5++;
        else if (i < r6_end) bad6++;
        else bad7++;
      end
    end
    check(bad5 == 0, "R5 pulse timing", bad5, 0);
    check(bad6 == 0, "R6 stop sequence", bad6, 0);
    check(bad7 == 0, "R7 reset and settle", bad7, 0);
    if (first >= 0)
      $display("  first mismatch cycle %0d code %0h exp %0h", first, tr[first], exp_code(first, p));
    check(dones == 1, "R10 one done cycle", dones, 1);
    check(pulse_count_o == 4'(p), (k > MP) ? "R4 pulse cap" : "R3 pulse count R8", pulse_count_o, p);
    if (k == 0) check(pulse_count_o == 0 && bad6 == 0, "R9 idle bus still stopped", pulse_count_o, 0);
    check(!scl_oe_o && !sda_oe_o && !done_o, "R10 quiet after done", {scl_oe_o, sda_oe_o, done_o}, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1C2D));
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !scl_oe_o && !sda_oe_o && !ctrl_rst_o && pulse_count_o == 0,
          "R1 reset state", {busy_o, done_o, scl_oe_o, sda_oe_o, ctrl_rst_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy_o && !scl_oe_o && !sda_oe_o, "R1 idle after reset", busy_o, 0);
    run(0, 1'b0);   // R9 idle bus
    run(1, 1'b0);   // R3 single pulse
    run(9, 1'b1);   // R4 exactly at budget, R2 spam
    run(10, 1'b0);  // R4 one beyond budget
    run(30, 1'b1);  // R4 stuck forever
    for (int j = 0; j < 10; j++) run(int'($urandom_range(0, 12)), 1'($urandom_range(0, 1)));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule